// File: doc/BRIEF.md
# Nibble-Serial 16-bit Adder/Subtractor

This unit adds or subtracts two 16-bit operands with one 4-bit adder. It uses that adder once per clock for four clocks. Work starts at the least significant nibble and moves toward the most significant one. The carry between nibbles is kept in two flag registers that take turns. The half-carry flag captures the carry of the first and third nibbles. The carry flag captures the carry of the second and fourth nibbles. When the operation ends, the carry flag holds the carry out of bit 15 and the half-carry flag holds the carry out of bit 11.

A one-cycle start pulse latches both operands, the add/subtract select and the carry-in-enable select. Subtraction adds the inverted second operand with an initial carry of one. The stored flags are the inverted carries, so after a subtraction they read as borrows. With carry-in enabled, the first nibble takes the carry flag left by the previous operation as its carry (add-with-carry) or as its borrow (subtract-with-borrow). A one-cycle done pulse marks the finished result. The result and both flags then hold until the next accepted start.

Top module: `nibble_serial_addsub`

## Requirements
- R1: While reset is active and after it is released, the result is 0, both flags are 0 and done is 0.
- R2: With sub=0 and carry-in disabled, the result is (A+B) mod 65536. Done is high for exactly one cycle, in the fourth cycle after the clock edge that accepted start.
- R3: After an addition, the carry flag equals the carry out of bit 15. The half-carry flag equals the carry out of bit 11, i.e. of A[11:0]+B[11:0] plus carry-in.
- R4: With sub=1 and carry-in disabled, the result is (A-B) mod 65536. The carry flag is 1 exactly when A<B, unsigned. The half-carry flag is 1 exactly when A[11:0]<B[11:0].
- R5: With sub=0 and carry-in enabled, the result and flags are those of A+B+Cp, where Cp is the carry flag before the start.
- R6: With sub=1 and carry-in enabled, the result and flags are those of A-B-Cp, with borrows computed as in R4 including Cp.
- R7: Start pulses that arrive while an operation is running are ignored. The running operation ends with its own result and no extra done pulse.
- R8: When idle with no start, the result and both flags keep their values.
- R9: Done is never high in two consecutive cycles.
- R10: The carry flag changes only on the second and fourth nibble steps. The half-carry flag changes only on the first and third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| opa_i | input | 16 | First operand A |
| opb_i | input | 16 | Second operand B |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| cin_en_i | input | 1 | 1 = use the prior carry flag as carry/borrow in |
| result_o | output | 16 | Result of the last operation |
| hflag_o | output | 1 | Half-carry flag (carry or borrow out of bit 11) |
| cflag_o | output | 1 | Carry flag (carry or borrow out of bit 15) |
| done_o | output | 1 | One-cycle pulse when the result is ready |

## Verification
Some operand pairs are chosen so that a carry must ripple across every nibble boundary, for example 0xFFFF+1 and 0x0FFF+1. A step that takes its carry-in from the wrong flag gives a wrong result on these. Other pairs, such as 0x8000+0x8000, carry only at the top, which separates the two flags. Borrow cases such as 0-1 and 0x1000-1 test the inverted-carry convention. Chained add-with-carry and subtract-with-borrow operations, run after operations that leave the carry flag set or clear, show whether the prior flag enters the first step. A mixed run of pseudo-random operands covers the remaining combinations.

// File: rtl/nsa_pkg.sv
// Shared types for the nibble-serial adder/subtractor.
// Assumes: nothing beyond IEEE 1800-2017.
package nsa_pkg;
    // Run state of the step sequencer.
    typedef enum logic {
        NSA_IDLE = 1'b0,
        NSA_RUN  = 1'b1
    } nsa_state_e;
endpackage

// File: rtl/nsa_nibble_alu.sv
// One narrow adder, shared by all steps of a wide add or subtract.
// For subtraction it inverts operand b; the caller supplies the carry-in.
// Assumes: purely combinational, no state.
module nsa_nibble_alu #(
    parameter int NIB_W = 4
) (
    input  logic [NIB_W-1:0] a_i,
    input  logic [NIB_W-1:0] b_i,
    input  logic             inv_b_i,
    input  logic             cin_i,
    output logic [NIB_W-1:0] sum_o,
    output logic             cout_o
);
    logic [NIB_W-1:0] b_eff;
    logic [NIB_W:0]   wide;

    // Select plain or inverted b and form the narrow sum with carry out.
    always_comb begin
        b_eff  = inv_b_i ? ~b_i : b_i;
        wide   = {1'b0, a_i} + {1'b0, b_eff} + {{NIB_W{1'b0}}, cin_i};
        sum_o  = wide[NIB_W-1:0];
        cout_o = wide[NIB_W];
    end
endmodule

// File: rtl/nsa_step_ctrl.sv
// Step sequencer: takes a start pulse when idle, counts STEPS steps,
// and raises done for one cycle after the last step.
// Assumes: start pulses during a run are ignored.
module nsa_step_ctrl
    import nsa_pkg::*;
#(
    parameter int STEPS = 4,
    localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          load_o,
    output logic          busy_o,
    output logic          first_o,
    output logic          last_o,
    output logic [SW-1:0] step_o,
    output logic          done_o
);
    nsa_state_e    state_q;
    logic [SW-1:0] step_q;
    logic          done_q;

    // Decode load and the first/last step markers.
    always_comb begin
        busy_o  = (state_q == NSA_RUN);
        load_o  = start_i && !busy_o;
        first_o = (step_q == '0);
        last_o  = (step_q == SW'(STEPS - 1));
        step_o  = step_q;
        done_o  = done_q;
    end

    // Advance the step counter and the run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NSA_IDLE;
            step_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= busy_o && last_o;
            if (load_o) begin
                state_q <= NSA_RUN;
                step_q  <= '0;
            end else if (busy_o) begin
                if (last_o) begin
                    state_q <= NSA_IDLE;
                    step_q  <= '0;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && last_o |=> done_o && !busy_o);
    p_run_continues_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !last_o |=> busy_o && (step_o == $past(step_o) + 1'b1));
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/nsa_flag_unit.sv
// Holds the half-carry (H) and carry (C) flags. Even-numbered steps
// write H and odd-numbered steps write C. It also supplies each step's
// carry-in: the flag written by the previous step, or, on the first step,
// the prior C (carry-in enabled) or nothing. Flags hold inverted carries
// during subtraction, so they read as borrows.
// Assumes: sub and cin_en stay constant for a whole run.
module nsa_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic first_i,
    input  logic step_odd_i,
    input  logic sub_i,
    input  logic cin_en_i,
    input  logic cout_i,
    output logic cin_o,
    output logic hflag_o,
    output logic cflag_o
);
    logic h_q, c_q;
    logic prev_flag;

    // Pick the flag that feeds this step, then convert it to the adder's carry.
    always_comb begin
        if (first_i) prev_flag = cin_en_i ? c_q : 1'b0;
        else         prev_flag = step_odd_i ? h_q : c_q;
        cin_o   = prev_flag ^ sub_i;
        hflag_o = h_q;
        cflag_o = c_q;
    end

    // Store this step's carry (or borrow) in H or C, alternating by step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= 1'b0;
            c_q <= 1'b0;
        end else if (busy_i) begin
            if (step_odd_i) c_q <= cout_i ^ sub_i;
            else            h_q <= cout_i ^ sub_i;
        end
    end

    p_c_only_odd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_i && step_odd_i) |=> $stable(c_q));
    p_h_only_even_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_i && !step_odd_i) |=> $stable(h_q));
endmodule

// File: rtl/nibble_serial_addsub.sv
// Top: a multi-cycle wide add/subtract built on one narrow adder. Operands
// are latched on an accepted start and shifted down one nibble per step.
// Each nibble sum is shifted into the result from the top.
// Assumes: STEPS is even, so the final carry lands in the C flag.
module nibble_serial_addsub #(
    parameter int NIB_W = 4,
    parameter int STEPS = 4,
    localparam int WORD_W = NIB_W * STEPS,
    localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] opb_i,
    input  logic              sub_i,
    input  logic              cin_en_i,
    output logic [WORD_W-1:0] result_o,
    output logic              hflag_o,
    output logic              cflag_o,
    output logic              done_o
);
    logic              load, busy, first, last;
    logic [SW-1:0]     step;
    logic [WORD_W-1:0] a_sh, b_sh, res_q;
    logic              sub_q, cen_q;
    logic [NIB_W-1:0]  nib_sum;
    logic              nib_cout, nib_cin;

    nsa_step_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .load_o(load), .busy_o(busy), .first_o(first), .last_o(last),
        .step_o(step), .done_o(done_o)
    );

    nsa_nibble_alu #(.NIB_W(NIB_W)) u_alu (
        .a_i(a_sh[NIB_W-1:0]), .b_i(b_sh[NIB_W-1:0]), .inv_b_i(sub_q),
        .cin_i(nib_cin), .sum_o(nib_sum), .cout_o(nib_cout)
    );

    nsa_flag_unit u_flags (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .first_i(first),
        .step_odd_i(step[0]), .sub_i(sub_q), .cin_en_i(cen_q),
        .cout_i(nib_cout), .cin_o(nib_cin),
        .hflag_o(hflag_o), .cflag_o(cflag_o)
    );

    // Latch operands on load; shift operands and fill the result on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_sh  <= '0;
            b_sh  <= '0;
            res_q <= '0;
            sub_q <= 1'b0;
            cen_q <= 1'b0;
        end else if (load) begin
            a_sh  <= opa_i;
            b_sh  <= opb_i;
            sub_q <= sub_i;
            cen_q <= cin_en_i;
        end else if (busy) begin
            a_sh  <= a_sh >> NIB_W;
            b_sh  <= b_sh >> NIB_W;
            res_q <= {nib_sum, res_q[WORD_W-1:NIB_W]};
        end
    end

    // Drive the result port.
    always_comb result_o = res_q;

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start_i |=> $stable(result_o) && $stable(hflag_o) && $stable(cflag_o));
    p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !last && start_i |=> busy && !done_o);
endmodule

// File: tb/tb_nibble_serial_addsub.sv
module tb_nibble_serial_addsub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] opa_i = '0, opb_i = '0;
    logic        sub_i = 1'b0, cin_en_i = 1'b0;
    logic [15:0] result_o;
    logic        hflag_o, cflag_o, done_o;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    logic model_c = 1'b0;

    typedef struct {
        logic [15:0] res;
        logic        h;
        logic        c;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb[$];

    nibble_serial_addsub dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opa_i(opa_i), .opb_i(opb_i),
        .sub_i(sub_i), .cin_en_i(cin_en_i), .result_o(result_o),
        .hflag_o(hflag_o), .cflag_o(cflag_o), .done_o(done_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop expected items and compare when done appears.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(result_o == e.res, {e.tag, " result"}, 32'(result_o), 32'(e.res));
                check(hflag_o == e.h, {e.tag, " H"}, 32'(hflag_o), 32'(e.h));
                check(cflag_o == e.c, {e.tag, " C"}, 32'(cflag_o), 32'(e.c));
                check(cyc == e.due, "R2 done latency", 32'(cyc), 32'(e.due));
            end
        end
    end

    // Driver: compute the expected outcome, queue it, and run one operation.
    task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic s,
                          input logic ce, input string tag, input bit poke_busy);
        exp_t e;
        logic bin;
        logic [16:0] w;
        @(negedge clk);
        bin = ce ? model_c : 1'b0;
        if (!s) begin
            w   = {1'b0, a} + {1'b0, b} + 17'(bin);
            e.res = w[15:0];
            e.c   = w[16];
            e.h   = ((13'(a[11:0]) + 13'(b[11:0]) + 13'(bin)) >> 12) != 0;
        end else begin
            e.res = a - b - 16'(bin);
            e.c   = 17'(a) < (17'(b) + 17'(bin));
            e.h   = 13'(a[11:0]) < (13'(b[11:0]) + 13'(bin));
        end
        model_c = e.c;
        e.due = cyc + 5;
        e.tag = tag;
        sb.push_back(e);
        opa_i = a; opb_i = b; sub_i = s; cin_en_i = ce; start_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (poke_busy && i < 3) begin
                start_i = 1'b1; opa_i = 16'h5A5A; opb_i = 16'hA5A5; sub_i = ~s;
            end else begin
                start_i = 1'b0;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] hr;
        logic hh, hc;
        logic [31:0] lfsr;
        int t;
        t = 0;
        lfsr = 32'h1ACE_B00C;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(result_o == 16'h0, "R1 result", 32'(result_o), 0);
        check({hflag_o, cflag_o, done_o} == 3'b000, "R1 flags/done", 32'({hflag_o, cflag_o, done_o}), 0);
        rst_n = 1'b1;

        run_op(16'h1234, 16'h5678, 0, 0, "R2 add plain", 0);
        run_op(16'h0FFF, 16'h0001, 0, 0, "R3 add carry bit11", 0);
        run_op(16'hFFFF, 16'h0001, 0, 0, "R3 add full ripple", 0);
        run_op(16'h8000, 16'h8000, 0, 0, "R3 add top carry", 0);
        run_op(16'h5678, 16'h1234, 1, 0, "R4 sub plain", 0);
        run_op(16'h1000, 16'h0001, 1, 0, "R4 sub borrow bit11", 0);
        run_op(16'h0000, 16'h0001, 1, 0, "R4 sub underflow", 0);
        run_op(16'h00FF, 16'h0000, 0, 1, "R5 adc with C set", 0);
        run_op(16'hFFFF, 16'h0001, 0, 0, "R3 set C", 0);
        run_op(16'h0FFF, 16'hF000, 0, 1, "R5 adc ripple", 0);
        run_op(16'h1000, 16'h0FFF, 1, 1, "R6 sbc with borrow", 0);
        run_op(16'h0005, 16'h0003, 1, 1, "R6 sbc no borrow", 0);
        run_op(16'h0000, 16'h0001, 1, 0, "R4 set borrow", 0);
        run_op(16'h0001, 16'h0000, 1, 1, "R6 sbc borrow chain", 0);
        run_op(16'h4321, 16'h1111, 0, 0, "R7 start while busy", 1);

        // R8: idle hold of result and flags
        hr = result_o; hh = hflag_o; hc = cflag_o;
        repeat (6) @(negedge clk);
        check(result_o == hr, "R8 result hold", 32'(result_o), 32'(hr));
        check({hflag_o, cflag_o} == {hh, hc}, "R8 flag hold", 32'({hflag_o, cflag_o}), 32'({hh, hc}));
        check(done_o == 1'b0, "R9 done idle", 32'(done_o), 0);

        for (int k = 0; k < 24; k++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            run_op(lfsr[31:16], lfsr[15:0], lfsr[7], lfsr[11], "R5 R6 mixed", 0);
        end
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R7 pending results", 32'(sb.size()), 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule